// File: doc/BRIEF.md
# Three-Bit-Coded Arithmetic Logic Unit

This block is the combinational arithmetic logic unit of a small load/store processor. It takes two operands and a three-bit operation code. It returns a result word, a flag that is high when that result is all zeros, and a signed-overflow flag. The controller uses the zero flag to decide a branch-on-equal. It uses the overflow flag to raise an exception.

The top bit of the operation code tells the shared adder to invert the second operand and add a carry of one. Subtraction and the signed less-than comparison therefore run on the same adder as addition. The two low bits pick the output source: bitwise AND, bitwise OR, adder sum, or comparison bit. Codes with no assigned meaning give a defined quiet output.

The block has no clock. Every output follows its inputs within the same evaluation. Because nothing is stored, none of its operating modes is a state or a transition. Each mode is a decoded value of the operation code.

Top module: `alu3_core`

## Requirements
- R1: Operation code 000 drives the result with the bitwise AND of operand A and operand B.
- R2: Operation code 001 drives the result with the bitwise OR of operand A and operand B.
- R3: Operation code 010 drives the result with A plus B, taken modulo 2^32.
- R4: Operation code 110 drives the result with A minus B, taken modulo 2^32.
- R5: Operation code 111 compares A and B as signed two's-complement values. Bit 0 of the result is 1 when A is less than B and 0 otherwise. Bits 31 to 1 of the result are 0.
- R6: The code 111 comparison stays correct when the difference A minus B overflows, for example when A is the most negative value and B is positive.
- R7: The zero output is 1 exactly when all 32 result bits are 0. This holds for every operation code.
- R8: For code 010, the overflow output is 1 only when both operands have the same sign and the sum has the opposite sign.
- R9: For code 110, the overflow output is 1 only when the operands differ in sign and the difference has a sign different from A.
- R10: For codes 000, 001 and 111, the overflow output is 0 whatever the operands are.
- R11: For each unassigned code (011, 100 and 101), the result is 0, the zero output is 1 and the overflow output is 0.
- R12: All outputs depend only on the present inputs. A new input value shows on the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| op_i | input | 3 | Operation code; bit 2 selects invert-and-carry on operand B |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench aims at the signed boundaries:
- **Overflow detection.** It drives sums of two large positives, sums of two large negatives, and differences of the most negative value with positive and negative operands. A flag taken from the carry-out instead of the sign rule would fire on harmless unsigned wrap, or miss a true overflow.
- **Comparison under overflow.** It compares across an overflowing subtraction. A comparison that reads only the raw sign of the difference would report the wrong answer there.
- **Comparison sign handling.** It runs an unsigned-looking case. An unsigned comparison would order a negative A above a positive B.
- **Unassigned codes.** Each unassigned code is tried with non-zero operands. A decoder that let the adder through would leak a sum, and the zero and overflow flags would show it.
- **Zero flag.** Subtractions of equal operands and sums that wrap to zero check that the flag tracks the full result word.

// File: rtl/alu3_pkg.sv
package alu3_pkg;
    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_RSV3 = 3'b011,
        OP_RSV4 = 3'b100,
        OP_RSV5 = 3'b101,
        OP_SUB  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;

    localparam int unsigned OP_W = 3;
endpackage

// File: rtl/alu3_addsub.sv
module alu3_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             inv_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;

    always_comb begin
        b_eff = b_i ^ {WIDTH{inv_i}};
        sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, inv_i};
        ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu3_logic.sv
module alu3_logic #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sel_or_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        if (sel_or_i) y_o = a_i | b_i;
        else          y_o = a_i & b_i;
    end
endmodule

// File: rtl/alu3_zero_det.sv
module alu3_zero_det #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             zero_o
);
    always_comb zero_o = ~(|word_i);
endmodule

// File: rtl/alu3_core.sv
module alu3_core
    import alu3_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o
);
    localparam int unsigned MSB = WIDTH - 1;

    alu_op_e          op_sel;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] logic_w;
    logic             add_ovf;
    logic             less_w;

    assign op_sel = alu_op_e'(op_i);

    alu3_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .inv_i (op_i[2]),
        .sum_o (sum_w),
        .ovf_o (add_ovf)
    );

    alu3_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i      (opa_i),
        .b_i      (opb_i),
        .sel_or_i (op_i[0]),
        .y_o      (logic_w)
    );

    alu3_zero_det #(.WIDTH(WIDTH)) u_zero (
        .word_i (result_o),
        .zero_o (zero_o)
    );

    // signed less-than: sign of the difference, corrected by its overflow
    assign less_w = sum_w[MSB] ^ add_ovf;

    always_comb begin
        result_o = '0;
        ovf_o    = 1'b0;
        unique case (op_sel)
            OP_AND, OP_OR: result_o = logic_w;
            OP_ADD, OP_SUB: begin
                result_o = sum_w;
                ovf_o    = add_ovf;
            end
            OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, less_w};
            default: result_o = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({opa_i, opb_i, op_i})) begin
            // R1
            and_mask_chk: assert (op_i != 3'b000 || (result_o & ~(opa_i & opb_i)) == '0);
            // R2
            or_cover_chk: assert (op_i != 3'b001 || (result_o & (opa_i | opb_i)) == (opa_i | opb_i));
            // R5
            slt_bit_chk: assert (op_i != 3'b111 || result_o[WIDTH-1:1] == '0);
            // R10
            no_overflow_chk: assert (!ovf_o || op_i == 3'b010 || op_i == 3'b110);
            // R7
            zero_flag_chk: assert (!zero_o || result_o == '0);
            // R11
            rsv_quiet_chk: assert (!(op_i inside {3'b011, 3'b100, 3'b101}) || (zero_o && !ovf_o));
            // R8
            add_sign_chk: assert (op_i != 3'b010 || !ovf_o || (opa_i[MSB] == opb_i[MSB] && result_o[MSB] != opa_i[MSB]));
        end
    end
endmodule

// File: tb/alu3_core_tb_top.sv
`timescale 1ns/1ps
module alu3_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opa, opb;
    logic [2:0]  op;
    logic [31:0] result;
    logic        zero, ovf;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          drv_done = 1'b0;
    bit          finished = 1'b0;

    logic [31:0] q_res[$];
    logic        q_z[$];
    logic        q_v[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    alu3_core dut_i (
        .opa_i    (opa),
        .opb_i    (opb),
        .op_i     (op),
        .result_o (result),
        .zero_o   (zero),
        .ovf_o    (ovf)
    );

    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [2:0] c, output logic [31:0] r,
                                  output logic v);
        logic signed [32:0] s;
        r = '0;
        v = 1'b0;
        case (c)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010: begin
                s = $signed({a[31], a}) + $signed({b[31], b});
                r = s[31:0];
                v = s[32] != s[31];
            end
            3'b110: begin
                s = $signed({a[31], a}) - $signed({b[31], b});
                r = s[31:0];
                v = s[32] != s[31];
            end
            3'b111: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: begin
                r = '0;
                v = 1'b0;
            end
        endcase
    endfunction

    task automatic drive(input logic [2:0] c, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        logic [31:0] r;
        logic        v;
        @(negedge clk);
        op  = c;
        opa = a;
        opb = b;
        model(a, b, c, r, v);
        q_res.push_back(r);
        q_z.push_back(r == 32'd0);
        q_v.push_back(v);
        q_tag.push_back(tag);
    endtask

    // monitor: results checked on the rising edge after each drive
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && q_res.size() > 0) begin
                logic [31:0] er;
                logic        ez, ev;
                string       t;
                er = q_res.pop_front();
                ez = q_z.pop_front();
                ev = q_v.pop_front();
                t  = q_tag.pop_front();
                n_run++;
                if (result !== er || zero !== ez || ovf !== ev) begin
                    n_fail++;
                    $display("FAIL %s: got res=%h z=%b v=%b, expected res=%h z=%b v=%b",
                             t, result, zero, ovf, er, ez, ev);
                end
            end
        end
    end

    initial begin
        op  = 3'b000;
        opa = '0;
        opb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // idle inputs: zero result, zero flag set (R7)
        drive(3'b000, 32'h0, 32'h0, "R7 idle");
        drive(3'b000, 32'hF0F0_1234, 32'h0FF0_FFFF, "R1 and");
        drive(3'b000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, "R1 and ones");
        drive(3'b001, 32'hF000_0001, 32'h0F00_0010, "R2 or");
        drive(3'b001, 32'h0, 32'h0, "R2 or zero R7");
        drive(3'b010, 32'd123456, 32'd654321, "R3 add");
        drive(3'b010, 32'hFFFF_FFFF, 32'h1, "R3 wrap zero R7");
        drive(3'b010, 32'h7FFF_FFFF, 32'h1, "R8 add pos ovf");
        drive(3'b010, 32'h8000_0000, 32'h8000_0000, "R8 add neg ovf");
        drive(3'b010, 32'h8000_0000, 32'h7FFF_FFFF, "R8 add mixed no ovf");
        drive(3'b110, 32'd1000, 32'd1, "R4 sub");
        drive(3'b110, 32'd5, 32'd9, "R4 sub negative");
        drive(3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R4 sub equal R7");
        drive(3'b110, 32'h8000_0000, 32'h1, "R9 sub ovf neg");
        drive(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R9 sub ovf pos");
        drive(3'b110, 32'hFFFF_FFFF, 32'h8000_0000, "R9 sub no ovf");
        drive(3'b111, 32'd3, 32'd7, "R5 slt true");
        drive(3'b111, 32'd7, 32'd3, "R5 slt false");
        drive(3'b111, 32'd7, 32'd7, "R5 slt equal");
        drive(3'b111, 32'hFFFF_FFFF, 32'd1, "R5 slt signed");
        drive(3'b111, 32'h8000_0000, 32'd1, "R6 slt min vs pos");
        drive(3'b111, 32'h7FFF_FFFF, 32'h8000_0000, "R6 slt max vs min");
        drive(3'b111, 32'h8000_0000, 32'h7FFF_FFFF, "R6 slt min vs max");
        drive(3'b000, 32'h8000_0000, 32'h8000_0000, "R10 and no ovf");
        drive(3'b001, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R10 or no ovf");
        drive(3'b011, 32'h7FFF_FFFF, 32'h1, "R11 code 011");
        drive(3'b100, 32'hFFFF_0000, 32'h0000_FFFF, "R11 code 100");
        drive(3'b101, 32'h8000_0000, 32'h1, "R11 code 101");
        // R12: back-to-back changes, each seen without an extra edge
        drive(3'b010, 32'd1, 32'd2, "R12 step a");
        drive(3'b110, 32'd1, 32'd2, "R12 step b");
        @(negedge clk);
        @(negedge clk);
        drv_done = 1'b1;
    end

    initial begin
        wait (drv_done && q_res.size() == 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule